// File: doc/BRIEF.md
# Oversampled Quadrature Pulse Counter

This block counts pulses on two slowly sampled inputs, S0 and S1, and keeps the result in an up/down counter that wraps at a programmable TOP value. Both inputs are brought into the sample clock domain and can optionally pass through a glitch filter. A filtered input only changes after it has held a new level for a programmable number of samples. The counter then advances in one of two families of operation. In single-input mode, edges of S0 are counted, and the direction comes from a configuration bit that S1 can optionally invert. In quadrature mode, the S0/S1 phase pair is decoded at one, two or four counts per cycle, and the direction follows which phase leads.

Software-style control arrives on plain configuration pins: the mode, the edge polarity, the direction, the filter settings, flutter removal and hysteresis. A load strobe writes the count and TOP values together. Wrapping past TOP or below zero raises a sticky overflow or underflow flag, which stays set until a clear strobe removes it. With hysteresis enabled, a wrap in either direction lands at TOP/2. The counter width is a parameter: 16 bits by default, and 8 bits is also supported.

Top module: `osq_pulse_counter`

## Requirements
- R1: After reset the count is 0, TOP is all ones, both flags are 0 and the mode is disabled; in disabled mode (mode code 0, and codes 5 to 7) input activity never changes the count.
- R2: In single-input mode (mode code 1), S0 edges of the selected polarity are counted: rising when edge_fall_i is 0, falling when it is 1. The count goes up when dir_down_i is 0 and down when it is 1. Without the filter, an S0 change driven before clock edge 1 shows in count_o after edge 4 and not after edge 3.
- R3: In single-input mode with s1_dir_en_i set, S1 high keeps the configured direction and S1 low reverses it.
- R4: Quadrature 1X (mode code 2) counts once per phase cycle. It counts up when S0 rises while S1 is low, and down when S0 falls while S1 is low. S0 leading S1 is the forward (up) direction.
- R5: Quadrature 2X (mode code 3) counts on both edges of S0, with the direction taken from the phase order.
- R6: Quadrature 4X (mode code 4) counts on every single-input change of S0 or S1. A sample in which both inputs change is ignored.
- R7: Counting up from a value at or above TOP wraps to 0 and sets ovf_o. Counting down from 0 wraps to TOP and sets unf_o.
- R8: With hyst_en_i set, both kinds of wrap reload the counter with TOP shifted right by one bit.
- R9: ovf_o and unf_o stay set until the matching flag_clr_i bit is pulsed (bit 0 clears overflow, bit 1 clears underflow). If a flag is set and cleared in the same cycle, setting wins.
- R10: A load_i pulse writes load_count_i into the count and load_top_i into TOP at the next clock edge. A load takes priority over a count in the same cycle.
- R11: With filt_en_i set in an enabled mode, an input level is accepted only after filt_len_i + 5 consecutive equal samples. Shorter pulses are dropped. An accepted change is counted after clock edge filt_len_i + 8 following the input change.
- R12: With flutter_en_i set in a quadrature mode, the first count after a direction reversal is dropped. Repeated toggling between two adjacent phase states therefore moves the count by at most one. A load clears the stored direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Mode code: 0 off, 1 single, 2 quad 1X, 3 quad 2X, 4 quad 4X |
| edge_fall_i | input | 1 | Single mode: count falling S0 edges |
| dir_down_i | input | 1 | Single mode: count down |
| s1_dir_en_i | input | 1 | Single mode: S1 low reverses the direction |
| filt_en_i | input | 1 | Glitch filter enable |
| filt_len_i | input | FILT_LEN_W | Filter length minus five |
| flutter_en_i | input | 1 | Quadrature flutter removal enable |
| hyst_en_i | input | 1 | Wrap to TOP/2 |
| load_i | input | 1 | Load strobe for count and TOP |
| load_count_i | input | CNT_W | Count value to load |
| load_top_i | input | CNT_W | TOP value to load |
| flag_clr_i | input | 2 | Flag clear strobes: bit 0 overflow, bit 1 underflow |
| s0_i | input | 1 | Pulse / phase A input |
| s1_i | input | 1 | Direction / phase B input |
| count_o | output | CNT_W | Current count |
| top_o | output | CNT_W | Current TOP |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |

## Verification
Without the filter, an input change needs four clock edges to reach count_o: two synchronizer stages, the clean register, and the counter. With the filter, the filter's acceptance window is added, so a change lands after edge filt_len_i + 8. Loads and flag clears take effect one edge after the strobe. The table-driven cases hold each phase state for six cycles, which is longer than the unfiltered latency, and sample only after the last state has settled. The directed latency and filter cases sample on the falling edge just before and just after the due edge, so one cycle early or late is caught.

// File: rtl/osq_pkg.sv
package osq_pkg;

  typedef enum logic [2:0] {
    MODE_OFF    = 3'd0,
    MODE_SINGLE = 3'd1,
    MODE_QUAD1  = 3'd2,
    MODE_QUAD2  = 3'd3,
    MODE_QUAD4  = 3'd4
  } osq_mode_e;

  // minimum number of equal samples the glitch filter demands
  localparam int OSQ_FILT_BASE = 5;

endpackage

// File: rtl/osq_input_filter.sv
module osq_input_filter #(
  parameter int FILT_LEN_W = 4,
  parameter int FILT_BASE  = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  active_i,
  input  logic [FILT_LEN_W-1:0] len_i,
  input  logic                  raw_i,
  output logic                  clean_o
);

  localparam int RUN_W = $clog2((1 << FILT_LEN_W) + FILT_BASE);

  logic             meta_q, samp_q, clean_q, clean_d, differ;
  logic [RUN_W-1:0] run_q, run_d, limit;

  // acceptance window: a new level must be seen len_i + FILT_BASE times
  always_comb begin
    limit   = RUN_W'(len_i) + RUN_W'(FILT_BASE - 1);
    differ  = samp_q ^ clean_q;
    clean_d = clean_q;
    run_d   = '0;
    if (!active_i) begin
      clean_d = samp_q;
    end else if (differ) begin
      if (run_q >= limit) clean_d = samp_q;
      else                run_d   = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      samp_q  <= 1'b0;
      clean_q <= 1'b0;
      run_q   <= '0;
    end else begin
      meta_q  <= raw_i;
      samp_q  <= meta_q;
      clean_q <= clean_d;
      run_q   <= run_d;
    end
  end

  assign clean_o = clean_q;

  // R11: while the window is still open the clean level must not move
  p_filter_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && differ && (run_q < limit)) |=> $stable(clean_q));

  // R11: an accepted level is always one the synchronizer presented
  p_filter_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clean_q) |-> (clean_q == $past(samp_q)));

endmodule

// File: rtl/osq_quad_decode.sv
module osq_quad_decode
  import osq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_i,
  input  logic       edge_fall_i,
  input  logic       dir_down_i,
  input  logic       s1_dir_en_i,
  input  logic       flutter_en_i,
  input  logic       restart_i,
  input  logic       s0_i,
  input  logic       s1_i,
  output logic       up_o,
  output logic       dn_o
);

  osq_mode_e mode_e;
  logic p0_q, p1_q;
  logic fv_q, fv_d, fdir_q, fdir_d;
  logic ch0, ch1, fwd, is_quad, cand, dir_up, drop;

  assign mode_e = osq_mode_e'(mode_i);

  always_comb begin
    ch0     = s0_i ^ p0_q;
    ch1     = s1_i ^ p1_q;
    // S0 leading S1 is forward: new S1 equals the old S0
    fwd     = (p0_q == s1_i);
    is_quad = 1'b0;
    cand    = 1'b0;
    dir_up  = fwd;
    case (mode_e)
      MODE_SINGLE: begin
        cand   = ch0 && (s0_i != edge_fall_i);
        dir_up = !(dir_down_i ^ (s1_dir_en_i & ~s1_i));
      end
      MODE_QUAD1: begin
        is_quad = 1'b1;
        cand    = ch0 && !ch1 && !s1_i;
      end
      MODE_QUAD2: begin
        is_quad = 1'b1;
        cand    = ch0 && !ch1;
      end
      MODE_QUAD4: begin
        is_quad = 1'b1;
        cand    = ch0 ^ ch1;
      end
      default: cand = 1'b0;
    endcase

    drop = flutter_en_i && is_quad && cand && fv_q && (fdir_q != dir_up);

    fv_d   = fv_q;
    fdir_d = fdir_q;
    if (restart_i) begin
      fv_d = 1'b0;
    end else if (is_quad && cand) begin
      fv_d   = 1'b1;
      fdir_d = dir_up;
    end

    up_o = cand && !drop && dir_up;
    dn_o = cand && !drop && !dir_up;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0_q   <= 1'b0;
      p1_q   <= 1'b0;
      fv_q   <= 1'b0;
      fdir_q <= 1'b1;
    end else begin
      p0_q   <= s0_i;
      p1_q   <= s1_i;
      fv_q   <= fv_d;
      fdir_q <= fdir_d;
    end
  end

  // R1: a disabled or unused mode code never produces a count
  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_e inside {MODE_SINGLE, MODE_QUAD1, MODE_QUAD2, MODE_QUAD4}) |-> (!up_o && !dn_o));

  // R4: 1X counts only on S0 edges taken while S1 stays low
  p_q1_s1low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_e == MODE_QUAD1) && (up_o || dn_o)) |-> (!s1_i && !p1_q));

  // R12: once a direction is stored, flutter removal only lets that direction through
  p_flutter_dir_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flutter_en_i && is_quad && fv_q && (up_o || dn_o)) |-> (up_o == fdir_q));

endmodule

// File: rtl/osq_count_core.sv
module osq_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_cnt_i,
  input  logic [CNT_W-1:0] load_top_i,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             hyst_i,
  input  logic [1:0]       clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] top_o,
  output logic             ovf_o,
  output logic             unf_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d, top_q, top_d, half;
  logic             ovf_q, ovf_d, unf_q, unf_d;

  always_comb begin
    half  = top_q >> 1;
    cnt_d = cnt_q;
    top_d = top_q;
    ovf_d = ovf_q & ~clr_i[0];
    unf_d = unf_q & ~clr_i[1];
    if (load_i) begin
      cnt_d = load_cnt_i;
      top_d = load_top_i;
    end else if (up_i) begin
      if (cnt_q >= top_q) begin
        cnt_d = hyst_i ? half : '0;
        ovf_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (dn_i) begin
      if (cnt_q == '0) begin
        cnt_d = hyst_i ? half : top_q;
        unf_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      top_q <= '1;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      top_q <= top_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign top_o = top_q;
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

  // R7 / R8: an overflow lands at zero or at the hysteresis midpoint
  p_wrap_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> ((cnt_q == '0) || (cnt_q == (top_q >> 1))));

  // R7 / R8: an underflow lands at TOP or at the hysteresis midpoint
  p_wrap_dn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unf_q) |-> ((cnt_q == top_q) || (cnt_q == (top_q >> 1))));

  // R9: flags only drop through their clear strobe
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_i[0]) |=> ovf_q);
  p_unf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_q && !clr_i[1]) |=> unf_q);

  // R10: a load writes both registers on the next edge
  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> ((cnt_q == $past(load_cnt_i)) && (top_q == $past(load_top_i))));

  // R1: without a load or a count event the counter holds
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !up_i && !dn_i) |=> $stable(cnt_q));

endmodule

// File: rtl/osq_pulse_counter.sv
module osq_pulse_counter
  import osq_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int FILT_LEN_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            mode_i,
  input  logic                  edge_fall_i,
  input  logic                  dir_down_i,
  input  logic                  s1_dir_en_i,
  input  logic                  filt_en_i,
  input  logic [FILT_LEN_W-1:0] filt_len_i,
  input  logic                  flutter_en_i,
  input  logic                  hyst_en_i,
  input  logic                  load_i,
  input  logic [CNT_W-1:0]      load_count_i,
  input  logic [CNT_W-1:0]      load_top_i,
  input  logic [1:0]            flag_clr_i,
  input  logic                  s0_i,
  input  logic                  s1_i,
  output logic [CNT_W-1:0]      count_o,
  output logic [CNT_W-1:0]      top_o,
  output logic                  ovf_o,
  output logic                  unf_o
);

  localparam int N_IN = 2;

  logic [1:0]      rst_pipe;
  logic            rst_n_s;
  logic            mode_on, filt_active;
  logic [N_IN-1:0] raw, clean;
  logic            ev_up, ev_dn;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  assign mode_on     = (mode_i >= 3'(MODE_SINGLE)) && (mode_i <= 3'(MODE_QUAD4));
  assign filt_active = filt_en_i && mode_on;
  assign raw         = {s1_i, s0_i};

  for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
    osq_input_filter #(
      .FILT_LEN_W (FILT_LEN_W),
      .FILT_BASE  (OSQ_FILT_BASE)
    ) u_filt (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .active_i (filt_active),
      .len_i    (filt_len_i),
      .raw_i    (raw[gi]),
      .clean_o  (clean[gi])
    );
  end

  osq_quad_decode u_dec (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .mode_i       (mode_i),
    .edge_fall_i  (edge_fall_i),
    .dir_down_i   (dir_down_i),
    .s1_dir_en_i  (s1_dir_en_i),
    .flutter_en_i (flutter_en_i),
    .restart_i    (load_i),
    .s0_i         (clean[0]),
    .s1_i         (clean[1]),
    .up_o         (ev_up),
    .dn_o         (ev_dn)
  );

  osq_count_core #(
    .CNT_W (CNT_W)
  ) u_core (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .load_i     (load_i),
    .load_cnt_i (load_count_i),
    .load_top_i (load_top_i),
    .up_i       (ev_up),
    .dn_i       (ev_dn),
    .hyst_i     (hyst_en_i),
    .clr_i      (flag_clr_i),
    .cnt_o      (count_o),
    .top_o      (top_o),
    .ovf_o      (ovf_o),
    .unf_o      (unf_o)
  );

  // R2 / R6: the decoder never asks for both directions at once
  p_one_dir_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(ev_up && ev_dn));

endmodule

// File: tb/osq_pulse_counter_test.sv
module osq_pulse_counter_test;

  localparam int CNT_W = 16;
  localparam int FLW   = 4;
  localparam int NV    = 15;

  typedef struct packed {
    logic [2:0]  mode;
    logic        fall;
    logic        down;
    logic        s1en;
    logic        flut;
    logic [1:0]  init;   // {s1,s0}
    logic [3:0]  nstep;
    logic [15:0] steps;  // step k at bits [2k+1:2k], each {s1,s0}
    logic [15:0] want;
  } vec_t;

  // every vector loads count 100 with TOP all ones before stepping
  localparam vec_t VECS [NV] = '{
    '{3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'd5, 16'h0111, 16'd103}, // R2 rising up
    '{3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 4'd5, 16'h0111, 16'd102}, // R2 falling
    '{3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 4'd5, 16'h0111, 16'd97},  // R2 down
    '{3'd1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 4'd3, 16'h0011, 16'd98},  // R3 s1 low
    '{3'd1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b10, 4'd3, 16'h003B, 16'd102}, // R3 s1 high
    '{3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'd8, 16'h2D2D, 16'd102}, // R4 fwd
    '{3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'd8, 16'h1E1E, 16'd98},  // R4 rev
    '{3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'd8, 16'h2D2D, 16'd104}, // R5 fwd
    '{3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'd8, 16'h1E1E, 16'd96},  // R5 rev
    '{3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'd8, 16'h2D2D, 16'd108}, // R6 fwd
    '{3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'd8, 16'h1E1E, 16'd92},  // R6 rev
    '{3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'd4, 16'h0033, 16'd100}, // R6 double change
    '{3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'd8, 16'h2D2D, 16'd100}, // R1 disabled
    '{3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'd4, 16'h0011, 16'd100}, // R12 no removal
    '{3'd4, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 4'd4, 16'h0011, 16'd101}  // R12 removal
  };

  logic             clk, rst_n;
  logic [2:0]       mode_i;
  logic             edge_fall_i, dir_down_i, s1_dir_en_i, filt_en_i;
  logic [FLW-1:0]   filt_len_i;
  logic             flutter_en_i, hyst_en_i, load_i;
  logic [CNT_W-1:0] load_count_i, load_top_i;
  logic [1:0]       flag_clr_i;
  logic             s0_i, s1_i;
  logic [CNT_W-1:0] count_o, top_o;
  logic             ovf_o, unf_o;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done     = 0;
  string tags [NV];

  osq_pulse_counter #(.CNT_W(CNT_W), .FILT_LEN_W(FLW)) uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .edge_fall_i(edge_fall_i),
    .dir_down_i(dir_down_i), .s1_dir_en_i(s1_dir_en_i), .filt_en_i(filt_en_i),
    .filt_len_i(filt_len_i), .flutter_en_i(flutter_en_i), .hyst_en_i(hyst_en_i),
    .load_i(load_i), .load_count_i(load_count_i), .load_top_i(load_top_i),
    .flag_clr_i(flag_clr_i), .s0_i(s0_i), .s1_i(s1_i), .count_o(count_o),
    .top_o(top_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] t);
    load_count_i = c;
    load_top_i   = t;
    load_i       = 1'b1;
    step(1);
    load_i       = 1'b0;
    step(1);
  endtask

  task automatic pulse_s0();
    s0_i = 1'b1;
    step(6);
    s0_i = 1'b0;
    step(6);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    tags = '{"R2", "R2", "R2", "R3", "R3", "R4", "R4", "R5", "R5",
             "R6", "R6", "R6", "R1", "R12", "R12"};
    rst_n = 1'b0; mode_i = 3'd0; edge_fall_i = 0; dir_down_i = 0; s1_dir_en_i = 0;
    filt_en_i = 0; filt_len_i = '0; flutter_en_i = 0; hyst_en_i = 0; load_i = 0;
    load_count_i = '0; load_top_i = '0; flag_clr_i = 2'b00; s0_i = 0; s1_i = 0;
    step(3);
    // R1 reset state
    chk("R1 count", 32'(count_o), 0);
    chk("R1 top", 32'(top_o), 32'hFFFF);
    chk("R1 ovf", 32'(ovf_o), 0);
    chk("R1 unf", 32'(unf_o), 0);
    rst_n = 1'b1;
    step(4);

    // table of vectors
    for (int v = 0; v < NV; v++) begin
      mode_i = 3'd0;
      {s1_i, s0_i} = VECS[v].init;
      step(8);
      edge_fall_i  = VECS[v].fall;
      dir_down_i   = VECS[v].down;
      s1_dir_en_i  = VECS[v].s1en;
      flutter_en_i = VECS[v].flut;
      mode_i       = VECS[v].mode;
      do_load(16'd100, 16'hFFFF);
      step(2);
      for (int k = 0; k < int'(VECS[v].nstep); k++) begin
        {s1_i, s0_i} = VECS[v].steps[2*k +: 2];
        step(6);
      end
      step(2);
      chk(tags[v], 32'(count_o), 32'(VECS[v].want));
    end

    // directed: single mode, rising, up
    mode_i = 3'd0; {s1_i, s0_i} = 2'b00; flutter_en_i = 0; s1_dir_en_i = 0;
    edge_fall_i = 0; dir_down_i = 0;
    step(6);
    mode_i = 3'd1;
    do_load(16'd20, 16'hFFFF);
    s0_i = 1'b1;
    step(3);
    chk("R2 latency early", 32'(count_o), 20);
    step(1);
    chk("R2 latency due", 32'(count_o), 21);
    s0_i = 1'b0;
    step(6);

    // R10 load of count and TOP
    do_load(16'd10, 16'd10);
    chk("R10 top", 32'(top_o), 10);
    chk("R10 count", 32'(count_o), 10);

    // R7 overflow wrap
    flag_clr_i = 2'b11; step(1); flag_clr_i = 2'b00; step(1);
    pulse_s0();
    chk("R7 overflow count", 32'(count_o), 0);
    chk("R7 overflow flag", 32'(ovf_o), 1);
    pulse_s0();
    chk("R9 count after wrap", 32'(count_o), 1);
    chk("R9 ovf sticky", 32'(ovf_o), 1);
    flag_clr_i = 2'b01; step(1); flag_clr_i = 2'b00; step(1);
    chk("R9 ovf cleared", 32'(ovf_o), 0);

    // R7 underflow wrap
    dir_down_i = 1'b1;
    do_load(16'd0, 16'd10);
    pulse_s0();
    chk("R7 underflow count", 32'(count_o), 10);
    chk("R7 underflow flag", 32'(unf_o), 1);
    chk("R9 ovf stays clear", 32'(ovf_o), 0);

    // R8 hysteresis
    hyst_en_i = 1'b1;
    do_load(16'd0, 16'd10);
    pulse_s0();
    chk("R8 underflow to half", 32'(count_o), 5);
    dir_down_i = 1'b0;
    do_load(16'd10, 16'd10);
    pulse_s0();
    chk("R8 overflow to half", 32'(count_o), 5);
    hyst_en_i = 1'b0;

    // R11 glitch filter, length 5 then 7
    filt_en_i = 1'b1; filt_len_i = '0;
    do_load(16'd50, 16'hFFFF);
    s0_i = 1'b1; step(4); s0_i = 1'b0; step(10);
    chk("R11 short pulse dropped", 32'(count_o), 50);
    s0_i = 1'b1;
    step(7);
    chk("R11 len0 early", 32'(count_o), 50);
    step(1);
    chk("R11 len0 due", 32'(count_o), 51);
    s0_i = 1'b0;
    step(10);
    filt_len_i = 4'd2;
    step(2);
    s0_i = 1'b1;
    step(9);
    chk("R11 len2 early", 32'(count_o), 51);
    step(1);
    chk("R11 len2 due", 32'(count_o), 52);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule